// File: doc/BRIEF.md
# Machine Event Counter Bank

This block holds the 64-bit machine counters of a processor core. It has a free-running cycle counter, a retired-instruction counter and a parameterised set of event counters numbered 3 upward. The pipeline sends the block one single-cycle strobe per event class. Each event counter has its own select mask over those strobes, and it advances by one in every cycle in which any of its selected strobes is high. A sleep input freezes every counter while the core is halted waiting for an interrupt.

Software reaches the block through a CSR-style port: a 12-bit address, a 32-bit write word with a write strobe, and a combinational read word. Every counter appears as two 32-bit halves. The same port reaches three sets of registers: a count-inhibit register, a user-access enable register and the per-counter select masks. A permission output tells the trap logic whether the current read is legal for the present privilege level. Position 1 of the counter index space belongs to the time value. This block does not count time. It only gates user reads of that slot, which read as zero.

Top module: `hpm_bank`

## Requirements
- R1: After reset, every counter, every select mask, the inhibit register and the access-enable register read as zero.
- R2: The cycle counter (index 0; machine address 0xB00 low half, 0xB80 high half) adds one on every clock edge where the core is not asleep and inhibit bit 0 is clear. The instret counter (index 2; 0xB02/0xB82) adds one on every edge where event bit 1 is high, the core is not asleep and inhibit bit 2 is clear.
- R3: The inhibit register sits at 0x320. Bit k (k ≥ 3) stops event counter k. Bit 1 and every bit above the last implemented counter are not stored and read as zero.
- R4: While the sleep input is high, no counter changes except through a CSR write.
- R5: Event counter k has its select mask at 0x320+k and its counter at 0xB00+k/0xB80+k. It adds exactly one per edge when its mask ANDed with the event strobes is non-zero, however many selected strobes coincide. The event bit positions are: 0 active cycle, 1 retired instruction, 2 retired compressed, 3 fetch wait, 4 flush issue wait, 5 load, 6 store, 7 load/store wait, 8 unconditional jump, 9 any conditional branch, 10 taken branch, 11 trap entry, 12 illegal instruction.
- R6: An event counter whose select mask is zero never increments.
- R7: A write to either half of a counter loads that half with the write word. The counter does not increment on that edge, and its other half keeps its value.
- R8: When the low half wraps from all ones on an increment, the high half adds one.
- R9: The user-read addresses 0xC00+k/0xC80+k return the same data as the machine counter k, and index 1 there returns zero.
- R10: In machine mode the permission output is high for every implemented address. In user mode it is high only for a user-read counter address whose access-enable bit k is set; the access-enable register is at 0x306, with bits 0, 1 and 2 for cycle, time and instret.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Core is asleep; freezes counting |
| evt_i | input | 13 | Single-cycle event strobes, bit positions as in R5 |
| priv_m_i | input | 1 | Current privilege is machine mode |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write word |
| csr_rdata_o | output | 32 | Combinational read word for csr_addr_i |
| csr_rd_ok_o | output | 1 | Read at csr_addr_i is permitted |

## Verification
Each increment, and each CSR write, lands in a register on the first rising edge after the stimulus. Its effect is visible one edge later. The read word and the permission flag follow the address within the same cycle, with no register in between. The bench therefore applies stimulus at a falling edge and lets exactly one rising edge pass. It then reads each result back through the address port at the next falling edge, after short settling delays, well before the following rising edge. Counter checks compare the change across that one edge, so the free-running cycle counter cannot shift the expected values.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
    localparam int XLEN  = 32;
    localparam int EVT_W = 13;

    // event strobe positions
    localparam int EV_ACTIVE    = 0;
    localparam int EV_RETIRE    = 1;
    localparam int EV_RET_C     = 2;
    localparam int EV_IF_WAIT   = 3;
    localparam int EV_FLUSH_IW  = 4;
    localparam int EV_LOAD      = 5;
    localparam int EV_STORE     = 6;
    localparam int EV_LS_WAIT   = 7;
    localparam int EV_JUMP      = 8;
    localparam int EV_BRANCH    = 9;
    localparam int EV_TAKEN     = 10;
    localparam int EV_TRAP      = 11;
    localparam int EV_ILLEGAL   = 12;

    localparam logic [11:0] ADDR_CNTEN   = 12'h306;
    localparam logic [11:0] ADDR_INHIBIT = 12'h320;
    localparam logic [3:0]  PAGE_MCNT    = 4'hB;
    localparam logic [3:0]  PAGE_UCNT    = 4'hC;
    localparam logic [6:0]  SEL_PAGE     = 7'h19; // 0x320 >> 5
endpackage

// File: rtl/hpm_counter.sv
module hpm_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                inc_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic [2*HALF_W-1:0] val_o
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_t;

    cnt_t         cnt_d, cnt_q;
    logic [HALF_W:0] lo_sum;

    always_comb begin
        cnt_d  = cnt_q;
        lo_sum = {1'b0, cnt_q.lo} + (HALF_W+1)'(1);
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) cnt_d.lo = wdata_i;
            if (wr_hi_i) cnt_d.hi = wdata_i;
        end else if (inc_i) begin
            cnt_d.lo = lo_sum[HALF_W-1:0];
            cnt_d.hi = cnt_q.hi + HALF_W'(lo_sum[HALF_W]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign val_o = cnt_q;

    // a write to the low half lands and holds the high half
    assert_write_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_lo_i && !wr_hi_i) |=> (val_o[HALF_W-1:0] == $past(wdata_i))
                                  && (val_o[2*HALF_W-1:HALF_W] == $past(val_o[2*HALF_W-1:HALF_W])));

    // wrap of the low half carries into the high half
    assert_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !wr_lo_i && !wr_hi_i && (&val_o[HALF_W-1:0]))
        |=> (val_o[2*HALF_W-1:HALF_W] == $past(val_o[2*HALF_W-1:HALF_W]) + HALF_W'(1))
            && (val_o[HALF_W-1:0] == '0));
endmodule

// File: rtl/hpm_csr_decode.sv
module hpm_csr_decode
    import hpm_pkg::*;
#(
    parameter int NUM_CNT = 7
) (
    input  logic [11:0] addr_i,
    output logic        m_cnt_o,
    output logic        u_cnt_o,
    output logic        half_hi_o,
    output logic        sel_o,
    output logic        inh_o,
    output logic        cen_o,
    output logic [4:0]  idx_o
);
    logic impl;

    always_comb begin
        idx_o     = addr_i[4:0];
        half_hi_o = addr_i[7];
        impl      = int'(idx_o) < NUM_CNT;
        m_cnt_o   = (addr_i[11:8] == PAGE_MCNT) && (addr_i[6:5] == 2'b00) && impl && (idx_o != 5'd1);
        u_cnt_o   = (addr_i[11:8] == PAGE_UCNT) && (addr_i[6:5] == 2'b00) && impl;
        inh_o     = (addr_i == ADDR_INHIBIT);
        cen_o     = (addr_i == ADDR_CNTEN);
        sel_o     = (addr_i[11:5] == SEL_PAGE) && (idx_o >= 5'd3) && impl;
    end
endmodule

// File: rtl/hpm_bank.sv
module hpm_bank
    import hpm_pkg::*;
#(
    parameter int NUM_HPM = 4   // event counters 3 .. 2+NUM_HPM, at most 29
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sleep_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             priv_m_i,
    input  logic [11:0]      csr_addr_i,
    input  logic             csr_we_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    output logic             csr_rd_ok_o
);
    localparam int          NUM_CNT   = 3 + NUM_HPM;
    localparam logic [31:0] IMPL_MASK = 32'((64'd1 << NUM_CNT) - 64'd1);
    localparam logic [31:0] INH_MASK  = IMPL_MASK & ~32'h2;

    typedef struct packed {
        logic [31:0]                       inh;
        logic [31:0]                       cen;
        logic [NUM_HPM-1:0][EVT_W-1:0]     sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic       dec_m, dec_u, dec_hi, dec_sel, dec_inh, dec_cen;
    logic [4:0] dec_idx;
    logic [2*XLEN-1:0] cnt_val [NUM_CNT];

    hpm_csr_decode #(.NUM_CNT(NUM_CNT)) u_dec (
        .addr_i    (csr_addr_i),
        .m_cnt_o   (dec_m),
        .u_cnt_o   (dec_u),
        .half_hi_o (dec_hi),
        .sel_o     (dec_sel),
        .inh_o     (dec_inh),
        .cen_o     (dec_cen),
        .idx_o     (dec_idx)
    );

    // counters: index 1 is the time slot and holds no storage here
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i == 1) begin : g_time
            assign cnt_val[i] = '0;
        end else begin : g_real
            logic inc_g, wl_g, wh_g;
            always_comb begin
                wl_g = csr_we_i && dec_m && !dec_hi && (dec_idx == 5'(i));
                wh_g = csr_we_i && dec_m &&  dec_hi && (dec_idx == 5'(i));
                if (i == 0)      inc_g = 1'b1;
                else if (i == 2) inc_g = evt_i[EV_RETIRE];
                else             inc_g = |(cfg_q.sel[(i>=3) ? i-3 : 0] & evt_i);
                inc_g = inc_g && !sleep_i && !cfg_q.inh[i];
            end
            hpm_counter #(.HALF_W(XLEN)) u_cnt (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .inc_i   (inc_g),
                .wr_lo_i (wl_g),
                .wr_hi_i (wh_g),
                .wdata_i (csr_wdata_i),
                .val_o   (cnt_val[i])
            );
        end
    end

    // configuration registers: next state
    always_comb begin
        cfg_d = cfg_q;
        if (csr_we_i) begin
            if (dec_inh) cfg_d.inh = csr_wdata_i & INH_MASK;
            if (dec_cen) cfg_d.cen = csr_wdata_i & IMPL_MASK;
            for (int k = 0; k < NUM_HPM; k++) begin
                if (dec_sel && dec_idx == 5'(k + 3)) cfg_d.sel[k] = csr_wdata_i[EVT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    // read mux and permission
    always_comb begin
        csr_rdata_o = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if ((dec_m || dec_u) && dec_idx == 5'(i))
                csr_rdata_o = dec_hi ? cnt_val[i][2*XLEN-1:XLEN] : cnt_val[i][XLEN-1:0];
        end
        for (int k = 0; k < NUM_HPM; k++) begin
            if (dec_sel && dec_idx == 5'(k + 3)) csr_rdata_o = XLEN'(cfg_q.sel[k]);
        end
        if (dec_inh) csr_rdata_o = cfg_q.inh;
        if (dec_cen) csr_rdata_o = cfg_q.cen;

        if (priv_m_i) csr_rd_ok_o = dec_m || dec_u || dec_sel || dec_inh || dec_cen;
        else          csr_rd_ok_o = dec_u && cfg_q.cen[dec_idx];
    end

    // sleep freezes the architectural counters
    assert_sleep_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_i && !csr_we_i) |=> ($stable(cnt_val[0]) && $stable(cnt_val[2])));

    // user mode never reaches machine-only addresses
    assert_user_perm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!priv_m_i && !dec_u) |-> !csr_rd_ok_o);

    // inhibit bit 0 holds the cycle counter
    assert_cycle_inhibit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.inh[0] && !csr_we_i) |=> $stable(cnt_val[0]));

    for (genvar k = 0; k < NUM_HPM; k++) begin : g_chk
        // an empty select mask never counts
        assert_zero_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((cfg_q.sel[k] == '0) && !csr_we_i) |=> $stable(cnt_val[k+3]));
    end
endmodule

// File: tb/tb_hpm_bank.sv
`timescale 1ns/10ps
module tb_hpm_bank;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        sleep_i = 1'b1;
    logic [12:0] evt_i = '0;
    logic        priv_m_i = 1'b1;
    logic [11:0] csr_addr_i = '0;
    logic        csr_we_i = 1'b0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        csr_rd_ok_o;

    int checks = 0;
    int fails  = 0;

    hpm_bank dut (.*);

    always #4 clk_i = ~clk_i;   // 125 MHz

    // {sleep, evt[12:0], d_cycle, d_instret, d_hpm3, d_hpm5}
    // hpm3 selects load|store, hpm4 selects nothing, hpm5 selects taken branch
    localparam logic [17:0] VEC [0:7] = '{
        {1'b0, 13'h0000, 4'b1000},
        {1'b0, 13'h0002, 4'b1100},
        {1'b0, 13'h0020, 4'b1010},
        {1'b0, 13'h0060, 4'b1010},
        {1'b1, 13'h0022, 4'b0000},
        {1'b0, 13'h1FFF, 4'b1111},
        {1'b0, 13'h0400, 4'b1001},
        {1'b0, 13'h0040, 4'b1010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        csr_addr_i = a;
        #0.1;
        d = csr_rdata_o;
    endtask

    task automatic rd_ok(input logic [11:0] a, output logic ok);
        csr_addr_i = a;
        #0.1;
        ok = csr_rd_ok_o;
    endtask

    // one rising edge with the given inputs; starts and ends at a falling edge
    task automatic step(input logic sl, input logic [12:0] ev, input logic we,
                        input logic [11:0] a, input logic [31:0] wd);
        sleep_i = sl; evt_i = ev; csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd;
        @(posedge clk_i);
        @(negedge clk_i);
        csr_we_i = 1'b0; evt_i = '0;
    endtask

    initial begin
        #1_600_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, b_c, b_i, b_3, b_4, b_5, a_c, a_i, a_3, a_4, a_5;
        logic ok;
        repeat (3) @(negedge clk_i);
        // R1: reset state
        rd(12'hB00, v); chk("R1 cycle", v, 0);
        rd(12'hB02, v); chk("R1 instret", v, 0);
        rd(12'hB03, v); chk("R1 hpm3", v, 0);
        rd(12'h323, v); chk("R1 sel3", v, 0);
        rd(12'h320, v); chk("R1 inhibit", v, 0);
        rd(12'h306, v); chk("R1 cnten", v, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        step(1'b1, '0, 1'b1, 12'h323, 32'h60);
        step(1'b1, '0, 1'b1, 12'h325, 32'h400);
        rd(12'h323, v); chk("R5 sel3 readback", v, 32'h60);

        // table walk: R2 R4 R5 R6
        for (int n = 0; n < 8; n++) begin
            rd(12'hB00, b_c); rd(12'hB02, b_i); rd(12'hB03, b_3);
            rd(12'hB04, b_4); rd(12'hB05, b_5);
            step(VEC[n][17], VEC[n][16:4], 1'b0, 12'h000, 32'h0);
            rd(12'hB00, a_c); rd(12'hB02, a_i); rd(12'hB03, a_3);
            rd(12'hB04, a_4); rd(12'hB05, a_5);
            chk($sformatf("R2/R4 cycle vec%0d", n), a_c - b_c, 32'(VEC[n][3]));
            chk($sformatf("R2/R4 instret vec%0d", n), a_i - b_i, 32'(VEC[n][2]));
            chk($sformatf("R5 hpm3 vec%0d", n), a_3 - b_3, 32'(VEC[n][1]));
            chk($sformatf("R5 hpm5 vec%0d", n), a_5 - b_5, 32'(VEC[n][0]));
            chk($sformatf("R6 hpm4 vec%0d", n), a_4 - b_4, 0);
        end

        // R7: write beats increment; other half held
        step(1'b0, 13'h0020, 1'b1, 12'hB03, 32'h1234);
        rd(12'hB03, v); chk("R7 lo write priority", v, 32'h1234);
        step(1'b0, 13'h0020, 1'b1, 12'hB83, 32'h7);
        rd(12'hB83, v); chk("R7 hi write", v, 32'h7);
        rd(12'hB03, v); chk("R7 lo held on hi write", v, 32'h1234);
        step(1'b0, 13'h0000, 1'b1, 12'hB00, 32'hABCD);
        rd(12'hB00, v); chk("R7 cycle write priority", v, 32'hABCD);

        // R8: carry
        step(1'b1, '0, 1'b1, 12'hB03, 32'hFFFF_FFFF);
        step(1'b1, '0, 1'b1, 12'hB83, 32'h5);
        step(1'b0, 13'h0020, 1'b0, 12'h000, 0);
        rd(12'hB03, v); chk("R8 lo wraps", v, 0);
        rd(12'hB83, v); chk("R8 hi carry", v, 6);

        // R2/R3: inhibit
        step(1'b0, '0, 1'b1, 12'h320, 32'h5);
        rd(12'hB00, b_c); rd(12'hB02, b_i); rd(12'hB03, b_3);
        step(1'b0, 13'h0022, 1'b0, 12'h000, 0);
        rd(12'hB00, a_c); rd(12'hB02, a_i); rd(12'hB03, a_3);
        chk("R2 cycle inhibited", a_c - b_c, 0);
        chk("R2 instret inhibited", a_i - b_i, 0);
        chk("R3 hpm3 not inhibited", a_3 - b_3, 1);
        step(1'b0, '0, 1'b1, 12'h320, 32'h8);
        rd(12'hB03, b_3); rd(12'hB00, b_c);
        step(1'b0, 13'h0020, 1'b0, 12'h000, 0);
        rd(12'hB03, a_3); rd(12'hB00, a_c);
        chk("R3 hpm3 inhibited", a_3 - b_3, 0);
        chk("R2 cycle resumes", a_c - b_c, 1);
        step(1'b1, '0, 1'b1, 12'h320, 32'hFFFF_FFFF);
        rd(12'h320, v); chk("R3 inhibit mask", v, 32'h7D);
        step(1'b1, '0, 1'b1, 12'h320, 32'h0);

        // R9: user view mirrors machine view
        rd(12'hB03, b_3); rd(12'hC03, a_3); chk("R9 user hpm3 lo", a_3, b_3);
        rd(12'hB83, b_3); rd(12'hC83, a_3); chk("R9 user hpm3 hi", a_3, b_3);
        rd(12'hC01, v); chk("R9 time slot zero", v, 0);

        // R10: permission
        priv_m_i = 1'b0;
        rd_ok(12'hC00, ok); chk("R10 user cycle denied", 32'(ok), 0);
        step(1'b1, '0, 1'b1, 12'h306, 32'h3);
        rd_ok(12'hC00, ok); chk("R10 user cycle allowed", 32'(ok), 1);
        rd_ok(12'hC01, ok); chk("R10 user time allowed", 32'(ok), 1);
        rd_ok(12'hC02, ok); chk("R10 user instret denied", 32'(ok), 0);
        rd_ok(12'hB00, ok); chk("R10 machine addr in user", 32'(ok), 0);
        priv_m_i = 1'b1;
        rd_ok(12'hB00, ok); chk("R10 machine addr in machine", 32'(ok), 1);
        rd_ok(12'hB01, ok); chk("R10 no machine time", 32'(ok), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule